// File: doc/BRIEF.md
# Serial Command Queue Sequencer

This block steps the queue pointer of a queued serial master through a 32-entry command queue. It begins at a programmable start pointer and runs to a programmable end pointer. For each entry it presents the queue address to an external transfer engine and raises a one-cycle start strobe. It then waits for a done pulse before it moves on. The serial shifting, the chip selects and the queue storage sit in that engine and are not part of this block.

A 16-bit control word sets the start and end pointers, the wrap behaviour and the finished-interrupt enable. CPU writes go to a shadow copy. That copy becomes active when the sequencer is idle, or in the cycle in which the transfer in flight reports done. Reads always return the active copy. When an applied write changes the start pointer, the queue restarts at that address. When the end entry completes, a sticky finished flag is set. The queue then stops or wraps, either to address 0 or back to the start pointer.

Top module: `cmdq_seq`

## Requirements
- R1: After reset, `cfg_rdata` is 0, `xfer_start`, `fin_flag` and `fin_irq` are 0, and no command is issued while `seq_en` stays low.
- R2: The control word layout is as follows. Bit 15 is the interrupt enable. Bit 14 is the wrap enable. Bit 13 is the wrap target (0 selects address 0, 1 selects the start pointer). Bits 12:8 hold the end pointer and bits 4:0 hold the start pointer. Bits 7:5 ignore writes and always read 0.
- R3: `cfg_rdata` shows the active word. A write becomes active one cycle after it is buffered when the sequencer is idle. Otherwise it becomes active in the cycle of the `xfer_done` that ends the transfer in flight, and until then `cfg_rdata` keeps the old value.
- R4: A rising edge on `seq_en` while idle starts the queue at the active start pointer. Each `xfer_start` lasts one cycle, and `xfer_addr` carries the entry's address.
- R5: Exactly one command is in flight at a time. The next `xfer_start` comes in the cycle after `xfer_done`, and in the ordinary case its address is the previous address plus one, modulo 32.
- R6: Completing the entry whose address equals the end pointer sets `fin_flag`. The flag stays set until `fin_clr` is pulsed. A set in the same cycle as a clear wins.
- R7: `fin_irq` equals `fin_flag` AND the active interrupt enable.
- R8: With wrap enabled, the command after the end entry is at address 0 when the wrap target is 0, or at the start pointer when it is 1.
- R9: With wrap disabled, no command follows the end entry and the sequencer stays idle.
- R10: An applied write whose start pointer differs from the active one makes the next command use the new start pointer. In the idle state with `seq_en` high, this also starts the queue.
- R11: If `seq_en` is low when `xfer_done` arrives, no further command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Sequencer enable; a rising edge starts the queue |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Active control word |
| fin_clr | input | 1 | Write-one pulse that clears the finished flag |
| fin_flag | output | 1 | Sticky end-of-queue flag |
| fin_irq | output | 1 | Finished interrupt |
| xfer_start | output | 1 | One-cycle command start strobe |
| xfer_addr | output | 5 | Queue address of the current command |
| xfer_done | input | 1 | Transfer engine completion pulse |

## Verification
A corrupted pointer shows up in `xfer_addr` at the very next `xfer_start`, which comes one cycle after the done pulse. A shadow word applied at the wrong moment changes `cfg_rdata` either before the done pulse or too late after it. A wrong end comparison shows up in the same cycle as a missing or spurious `fin_flag`, and in the wrong choice between stopping and wrapping. The bench acts as the transfer engine. It drives random delays and random mid-transfer writes, and it predicts every address, the flag and the interrupt with its own model.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int QDEPTH = 32;
  localparam int PTR_W  = $clog2(QDEPTH);
  localparam int CFG_W  = 16;
  localparam int RSV_W  = CFG_W - 3 - 2 * PTR_W;

  typedef struct packed {
    logic             fin_ie;
    logic             wrap_en;
    logic             wrap_sel;
    logic [PTR_W-1:0] end_ptr;
    logic [RSV_W-1:0] rsv;
    logic [PTR_W-1:0] start_ptr;
  } cfg_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/cmdq_cfg_buf.sv
module cmdq_cfg_buf
  import cmdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             apply_ok,
  output cfg_t             act_q,
  output cfg_t             pend_q,
  output logic             apply
);
  logic pend_vld_q, pend_vld_d;
  cfg_t pend_d, act_d;

  assign apply = pend_vld_q & apply_ok;

  always_comb begin
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    act_d      = act_q;
    if (apply) begin
      act_d      = pend_q;
      pend_vld_d = 1'b0;
    end
    if (wr) begin
      pend_d     = cfg_t'(wdata);
      pend_d.rsv = '0;
      pend_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      act_q      <= act_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  // R3: the active word only moves on an apply
  p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(act_q));
  // R2: reserved field never becomes active
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (act_q.rsv == '0));
endmodule

// File: rtl/cmdq_seq_fsm.sv
module cmdq_seq_fsm
  import cmdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [PTR_W-1:0] end_ptr,
  input  logic             wrap_en,
  input  logic             wrap_sel,
  input  logic [PTR_W-1:0] pend_start,
  input  logic             apply,
  input  logic             xfer_done,
  output logic             apply_ok,
  output logic             end_hit,
  output logic             xfer_start,
  output logic [PTR_W-1:0] xfer_addr
);
  sq_state_e        st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             en_q;
  logic             restart, en_rise, done_w;

  assign done_w   = (st_q == SQ_WAIT) & xfer_done;
  assign apply_ok = (st_q == SQ_IDLE) | done_w;
  assign restart  = apply & (pend_start != start_ptr);
  assign en_rise  = en & ~en_q;
  assign end_hit  = done_w & (ptr_q == end_ptr);

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (en && restart) begin
          ptr_d = pend_start;
          st_d  = SQ_ISSUE;
        end else if (en_rise) begin
          ptr_d = apply ? pend_start : start_ptr;
          st_d  = SQ_ISSUE;
        end
      end
      SQ_ISSUE: st_d = SQ_WAIT;
      SQ_WAIT: begin
        if (xfer_done) begin
          if (!en) begin
            st_d = SQ_IDLE;
          end else if (restart) begin
            ptr_d = pend_start;
            st_d  = SQ_ISSUE;
          end else if (end_hit) begin
            if (wrap_en) begin
              ptr_d = wrap_sel ? start_ptr : '0;
              st_d  = SQ_ISSUE;
            end else begin
              st_d = SQ_IDLE;
            end
          end else begin
            ptr_d = ptr_q + 1'b1;
            st_d  = SQ_ISSUE;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      ptr_q <= '0;
      en_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      en_q  <= en;
    end
  end

  assign xfer_start = (st_q == SQ_ISSUE);
  assign xfer_addr  = ptr_q;

  // R4: start strobe is a single cycle
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  // R5: nothing new while a transfer is outstanding
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WAIT && !xfer_done) |=> (!xfer_start && $stable(xfer_addr)));
  // R5: ordinary step is +1 modulo depth
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && en && !restart && !end_hit) |=>
      (xfer_start && xfer_addr == PTR_W'($past(xfer_addr) + 1'b1)));
  // R9: stop at the end entry without wrap
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hit && !wrap_en && !restart) |=> !xfer_start);
endmodule

// File: rtl/cmdq_fin_stat.sv
module cmdq_fin_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic fin_q,
  output logic irq
);
  logic fin_d;

  always_comb begin
    fin_d = fin_q;
    if (clr) fin_d = 1'b0;
    if (set) fin_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fin_q <= 1'b0;
    else        fin_q <= fin_d;
  end

  assign irq = fin_q & ie;

  // R6: end match always sets the flag
  p_fin_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> fin_q);
  // R6: flag is sticky until cleared
  p_fin_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && !clr) |=> fin_q);
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_en,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             fin_clr,
  output logic             fin_flag,
  output logic             fin_irq,
  output logic             xfer_start,
  output logic [PTR_W-1:0] xfer_addr,
  input  logic             xfer_done
);
  logic [1:0] rst_sync_q;
  logic       rst_s;
  cfg_t       act, pend;
  logic       apply, apply_ok, end_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  cmdq_cfg_buf u_cfg (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .apply_ok (apply_ok),
    .act_q    (act),
    .pend_q   (pend),
    .apply    (apply)
  );

  cmdq_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_s),
    .en         (seq_en),
    .start_ptr  (act.start_ptr),
    .end_ptr    (act.end_ptr),
    .wrap_en    (act.wrap_en),
    .wrap_sel   (act.wrap_sel),
    .pend_start (pend.start_ptr),
    .apply      (apply),
    .xfer_done  (xfer_done),
    .apply_ok   (apply_ok),
    .end_hit    (end_hit),
    .xfer_start (xfer_start),
    .xfer_addr  (xfer_addr)
  );

  cmdq_fin_stat u_fin (
    .clk   (clk),
    .rst_n (rst_s),
    .set   (end_hit),
    .clr   (fin_clr),
    .ie    (act.fin_ie),
    .fin_q (fin_flag),
    .irq   (fin_irq)
  );

  assign cfg_rdata = act;

  logic unused_pend;
  assign unused_pend = ^{pend.fin_ie, pend.wrap_en, pend.wrap_sel, pend.end_ptr, pend.rsv};
endmodule

// File: tb/tb_cmdq_seq.sv
`timescale 1ns/1ps
module tb_cmdq_seq;
  logic        clk = 1'b0;
  logic        rst_n, seq_en, cfg_wr, fin_clr, xfer_done;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        fin_flag, fin_irq, xfer_start;
  logic [4:0]  xfer_addr;

  int checks = 0;
  int errors = 0;

  logic [15:0] act_m;
  logic [4:0]  exp_addr;
  logic        exp_fin;
  bit          exp_idle;

  localparam logic [15:0] RSV = 16'h00E0;

  always #4 clk = ~clk;

  cmdq_seq dut (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fin_clr(fin_clr),
    .fin_flag(fin_flag), .fin_irq(fin_irq), .xfer_start(xfer_start),
    .xfer_addr(xfer_addr), .xfer_done(xfer_done)
  );

  function automatic logic [15:0] mk(input bit ie, input bit wr, input bit sel,
                                     input logic [4:0] e, input logic [4:0] s);
    return {ie, wr, sel, e, 3'b000, s};
  endfunction

  // returns {stop, next address}
  function automatic logic [5:0] nxt(input logic [4:0] a, input logic [15:0] oldc,
                                     input logic [15:0] newc, input bit wrote);
    if (wrote && newc[4:0] != oldc[4:0]) return {1'b0, newc[4:0]};
    if (a == oldc[12:8]) begin
      if (oldc[14]) return {1'b0, (oldc[13] ? oldc[4:0] : 5'd0)};
      return {1'b1, 5'd0};
    end
    return {1'b0, 5'(a + 5'd1)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic no_start(input string req);
    bit seen = 0;
    for (int i = 0; i < 8; i++) begin
      if (xfer_start) seen = 1;
      @(negedge clk);
    end
    check(req, seen, 0);
  endtask

  task automatic serve(input bit do_wr, input logic [15:0] wv, input int dly, input bit drop_en);
    int n = 0;
    logic [15:0] oldc;
    logic [5:0]  r;
    while (!xfer_start && n < 40) begin @(negedge clk); n++; end
    check("R5 start issued", xfer_start, 1);
    check("R4/R5 address", xfer_addr, exp_addr);
    @(negedge clk);
    check("R4 one-cycle strobe", xfer_start, 0);
    repeat (dly) @(negedge clk);
    oldc = act_m;
    if (do_wr) begin
      write_cfg(wv);
      check("R3 buffered until done", cfg_rdata, oldc);
    end
    if (drop_en) seq_en = 1'b0;
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    if (do_wr) act_m = wv & ~RSV;
    if (exp_addr == oldc[12:8]) exp_fin = 1'b1;
    check("R3 applied at done", cfg_rdata, act_m);
    check("R6 finished flag", fin_flag, exp_fin);
    check("R7 interrupt", fin_irq, exp_fin & act_m[15]);
    r = nxt(exp_addr, oldc, act_m, do_wr);
    if (drop_en) begin
      exp_idle = 1; no_start("R11 disable stops");
    end else if (r[5]) begin
      exp_idle = 1; no_start("R9 stop without wrap");
    end else begin
      exp_idle = 0; exp_addr = r[4:0];
    end
  endtask

  task automatic resume();
    seq_en = 1'b0;
    @(negedge clk);
    seq_en = 1'b1;
    exp_addr = act_m[4:0];
    exp_idle = 0;
  endtask

  task automatic clear_fin();
    fin_clr = 1'b1;
    @(negedge clk);
    fin_clr = 1'b0;
    exp_fin = 1'b0;
    check("R6 clear", fin_flag, 0);
    check("R7 irq after clear", fin_irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; seq_en = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    fin_clr = 1'b0; xfer_done = 1'b0;
    act_m = '0; exp_addr = '0; exp_fin = 1'b0; exp_idle = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rdata reset", cfg_rdata, 0);
    check("R1 start reset", xfer_start, 0);
    check("R1 flag reset", fin_flag, 0);
    check("R1 irq reset", fin_irq, 0);

    // R2/R3: idle write with reserved bits set, enable low
    write_cfg(mk(1, 0, 0, 5'd5, 5'd2) | RSV);
    @(negedge clk);
    act_m = mk(1, 0, 0, 5'd5, 5'd2);
    check("R2 reserved read 0 / R3 idle apply", cfg_rdata, act_m);
    no_start("R1 idle while disabled");

    // R4, R5, R9: run 2..5 then stop
    seq_en = 1'b1; exp_addr = 5'd2;
    for (int i = 0; i < 4; i++) serve(0, 0, i % 3, 0);
    check("R9 idle expected", exp_idle, 1);
    clear_fin();

    // R10 idle restart, R8 wrap to 0, R7 masked interrupt
    write_cfg(mk(0, 1, 0, 5'd31, 5'd30));
    act_m = mk(0, 1, 0, 5'd31, 5'd30); exp_addr = 5'd30;
    @(negedge clk);
    check("R3 idle apply", cfg_rdata, act_m);
    serve(0, 0, 1, 0);                       // 30
    serve(0, 0, 0, 0);                       // 31, end, irq masked
    check("R8 wrap to zero", exp_addr, 0);
    serve(0, 0, 2, 0);                       // 0
    serve(0, 0, 0, 0);                       // 1
    serve(1, mk(1, 1, 1, 5'd3, 5'd30), 1, 0); // 2, buffered write
    serve(0, 0, 0, 0);                       // 3, end, wrap to start
    check("R8 wrap to start", exp_addr, 30);
    serve(1, mk(1, 1, 1, 5'd3, 5'd9), 0, 0); // 30, restart at 9
    check("R10 restart pointer", exp_addr, 9);
    serve(0, 0, 1, 1);                       // 9, enable dropped
    resume();
    serve(0, 0, 0, 0);                       // 9 again

    // random traffic
    for (int k = 0; k < 300; k++) begin
      if (exp_idle) begin
        if ($urandom % 2 == 0) clear_fin();
        resume();
      end
      serve(($urandom % 4) == 0, 16'($urandom), int'($urandom % 4), ($urandom % 20) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule